// File: doc/BRIEF.md
# Interrupt Cause Collector with Rate Limiting and Delay Timers

This block gathers interrupt causes from the receive and transmit paths of a network controller into a pending-cause register. It gates the pending causes with a mask and drives one interrupt line to the host. A throttle counter limits how often that line may rise. Each cause post carries an immediate flag, and an immediate post skips the throttle. The host clears the pending causes by reading them.

The block also owns four one-shot delay timers: a per-packet and an absolute timer for receive, and the same pair for transmit. When a receive timer runs out, the block pulses a request for a full receive descriptor writeback with alignment mask zero, and posts the receive-timer cause immediately. The transmit timers do the same on the transmit side with the writeback-done cause. When a transmit writeback finishes, that cause is also posted through the throttled path. All timers count in ticks of 1024 ns. A free-running prescaler makes these ticks from the core clock.

Top module: `irq_moderator`

## Requirements
- R1: After reset the pending causes, the mask and the interrupt line are zero. A post on cause i sets bit i of `cause_rdata` one cycle later, whether or not the cause is masked.
- R2: A mask bit of 1 enables its cause. A non-immediate post of an enabled cause raises `irq` one cycle later when the throttle counter is zero. A post of a disabled cause leaves `irq` low.
- R3: A post whose matching `post_imm` bit is 1 raises `irq` one cycle later if its cause is enabled, even while the throttle counter is running.
- R4: A non-immediate post of an enabled cause that arrives while the throttle counter is running does not raise `irq`. It is held, and `irq` rises one cycle after the counter reaches zero.
- R5: Each rising edge of `irq` reloads the throttle counter from `thr_interval`, in ticks. A later non-immediate post is then held.
- R6: In a cycle with a write to the mask, the set bits are ORed in first and then the clear bits are removed, so clear wins. The line is then re-evaluated: it rises if any enabled cause is pending, and falls if none is.
- R7: A read returns the pending bits in `cause_rdata` during the read cycle. One cycle later it has cleared them and dropped `irq`. Posts made in the read cycle survive the clear.
- R8: Timer 0 (receive per-packet) and timer 1 (receive absolute) are receive timers. When one expires, the block pulses `rx_wb_req` for one cycle, and in that same cycle cause bit 7 is pending and `irq` is high if bit 7 is enabled.
- R9: Timer 2 (transmit per-packet) and timer 3 (transmit absolute) are transmit timers. When one expires, the block pulses `tx_wb_req`, and in that same cycle cause bit 0 is pending and `irq` is high if bit 0 is enabled.
- R10: A `txwb_done` pulse posts cause bit 0 through the non-immediate, throttled path.
- R11: A load pulse with value 0 stops a timer. A load with value N>0 arms the timer for exactly one expiry.
- R12: A tick comes every `PRESCALE` core cycles. A timer loaded with N expires between (N-1)*PRESCALE+1 and N*PRESCALE cycles after the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_vec | input | 8 | Cause post strobes, one per cause |
| post_imm | input | 8 | Immediate flag for each post |
| mask_set_we | input | 1 | OR `mask_wdata` into the mask |
| mask_clr_we | input | 1 | Clear the mask bits set in `mask_wdata` |
| mask_wdata | input | 8 | Mask write data |
| cause_rd | input | 1 | Read-to-clear strobe for the pending causes |
| cause_rdata | output | 8 | Pending cause bits |
| thr_interval | input | TMR_W | Throttle reload value in ticks |
| tmr_load | input | 4 | Load strobes for timers 0..3 |
| tmr_value | input | TMR_W | Load value for the timers, 0 stops the timer |
| txwb_done | input | 1 | A transmit descriptor writeback has completed |
| rx_wb_req | output | 1 | Request a full receive descriptor writeback |
| tx_wb_req | output | 1 | Request a full transmit descriptor writeback |
| irq | output | 1 | Interrupt line to the host |

## Verification
The assertions assume that the strobes are clean single-cycle levels sampled at the clock edge. They also assume that the interval and the timer value hold steady during the cycle of a load or reload. The bench meets this by driving every input just after a rising edge, and by changing `thr_interval` only while the line is not about to rise. Timer and throttle windows depend on the phase of the prescaler, so the bench checks them against cycle ranges rather than single cycles. The random phase runs with the throttle interval at zero and the timers idle, so a bench function can predict the line and the pending bits cycle by cycle.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int NUM_CAUSE  = 8;
  localparam int CAUSE_TXWB = 0;
  localparam int CAUSE_RXT  = 7;
  localparam int NUM_TMR    = 4;
  localparam int TMR_RX_PKT = 0;
  localparam int TMR_RX_ABS = 1;
  localparam int TMR_TX_PKT = 2;
  localparam int TMR_TX_ABS = 3;
endpackage

// File: rtl/irqm_prescaler.sv
module irqm_prescaler #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  always_comb begin
    at_end = (cnt_q == CW'(DIV - 1));
    cnt_d  = at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = at_end;

  generate
    if (DIV > 1) begin : g_chk
      p_tick_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/irqm_delay_timer.sv
module irqm_delay_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                      cnt_d = value;
    else if (tick && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = !load && tick && (cnt_q == W'(1));

  // R11: an idle timer stays idle until loaded
  p_one_shot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> cnt_q == '0);
  p_expire_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cnt_q == '0);
endmodule

// File: rtl/irqm_throttle.sv
module irqm_throttle #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         reload,
  input  logic [W-1:0] interval,
  output logic         running
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (reload)                    cnt_d = interval;
    else if (tick && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign running = (cnt_q != '0);

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt_q == $past(interval));
endmodule

// File: rtl/irqm_cause_core.sv
module irqm_cause_core #(
  parameter int NC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] post_vec,
  input  logic [NC-1:0] imm_vec,
  input  logic          mask_set_we,
  input  logic          mask_clr_we,
  input  logic [NC-1:0] mask_wdata,
  input  logic          cause_rd,
  input  logic          thr_running,
  output logic [NC-1:0] pending_q,
  output logic [NC-1:0] mask_q,
  output logic          irq_q,
  output logic          thr_reload
);
  logic [NC-1:0] pend_d, mask_d, active;
  logic          irq_d, held_q, held_d;
  logic          imm_hit, norm_hit, release_hit, mask_hit, fire;

  always_comb begin
    mask_d = mask_q;
    if (mask_set_we) mask_d = mask_d | mask_wdata;
    if (mask_clr_we) mask_d = mask_d & ~mask_wdata;

    pend_d      = (cause_rd ? '0 : pending_q) | post_vec;
    active      = pend_d & mask_d;
    imm_hit     = |(post_vec & imm_vec & mask_d);
    norm_hit    = |(post_vec & ~imm_vec & mask_d);
    release_hit = held_q && !thr_running;
    mask_hit    = mask_set_we || mask_clr_we;
    fire        = imm_hit || (norm_hit && !thr_running) || release_hit || mask_hit;
    irq_d       = (|active) && (irq_q || fire);

    held_d = held_q;
    if (!thr_running)            held_d = 1'b0;
    if (norm_hit && thr_running) held_d = 1'b1;

    thr_reload = irq_d && !irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
      mask_q    <= '0;
      irq_q     <= 1'b0;
      held_q    <= 1'b0;
    end else begin
      pending_q <= pend_d;
      mask_q    <= mask_d;
      irq_q     <= irq_d;
      held_q    <= held_d;
    end
  end

  p_irq_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> |(pending_q & mask_q));
  p_post_latched_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|post_vec) |=> ((pending_q & $past(post_vec)) == $past(post_vec)));
  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_rd && post_vec == '0) |=> (pending_q == '0 && !irq_q));
  p_imm_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_set_we && !mask_clr_we && |(post_vec & imm_vec & mask_q)) |=> irq_q);
  p_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_running && !irq_q && (post_vec & imm_vec) == '0 &&
     !mask_set_we && !mask_clr_we) |=> !irq_q);
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator #(
  parameter int TMR_W    = 16,
  parameter int PRESCALE = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       post_vec,
  input  logic [7:0]       post_imm,
  input  logic             mask_set_we,
  input  logic             mask_clr_we,
  input  logic [7:0]       mask_wdata,
  input  logic             cause_rd,
  output logic [7:0]       cause_rdata,
  input  logic [TMR_W-1:0] thr_interval,
  input  logic [3:0]       tmr_load,
  input  logic [TMR_W-1:0] tmr_value,
  input  logic             txwb_done,
  output logic             rx_wb_req,
  output logic             tx_wb_req,
  output logic             irq
);
  import irqm_pkg::*;

  localparam int NC = NUM_CAUSE;

  logic               tick, thr_running, thr_reload;
  logic [NUM_TMR-1:0] tmr_exp;
  logic               rx_exp, tx_exp;
  logic [NC-1:0]      post_all, imm_all, pending, mask;
  logic               rx_req_q, rx_req_d, tx_req_q, tx_req_d;

  irqm_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  generate
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      irqm_delay_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .load(tmr_load[t]), .value(tmr_value), .expire(tmr_exp[t])
      );
    end
  endgenerate

  always_comb begin
    rx_exp   = tmr_exp[TMR_RX_PKT] | tmr_exp[TMR_RX_ABS];
    tx_exp   = tmr_exp[TMR_TX_PKT] | tmr_exp[TMR_TX_ABS];
    post_all = post_vec;
    imm_all  = post_vec & post_imm;
    if (rx_exp) begin
      post_all[CAUSE_RXT] = 1'b1;
      imm_all[CAUSE_RXT]  = 1'b1;
    end
    if (tx_exp) begin
      post_all[CAUSE_TXWB] = 1'b1;
      imm_all[CAUSE_TXWB]  = 1'b1;
    end
    if (txwb_done) post_all[CAUSE_TXWB] = 1'b1;
    rx_req_d = rx_exp;
    tx_req_d = tx_exp;
  end

  irqm_throttle #(.W(TMR_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload(thr_reload),
    .interval(thr_interval), .running(thr_running)
  );

  irqm_cause_core #(.NC(NC)) u_core (
    .clk(clk), .rst_n(rst_n), .post_vec(post_all), .imm_vec(imm_all),
    .mask_set_we(mask_set_we), .mask_clr_we(mask_clr_we),
    .mask_wdata(mask_wdata), .cause_rd(cause_rd),
    .thr_running(thr_running), .pending_q(pending), .mask_q(mask),
    .irq_q(irq), .thr_reload(thr_reload)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_req_q <= 1'b0;
      tx_req_q <= 1'b0;
    end else begin
      rx_req_q <= rx_req_d;
      tx_req_q <= tx_req_d;
    end
  end

  assign rx_wb_req   = rx_req_q;
  assign tx_wb_req   = tx_req_q;
  assign cause_rdata = pending;

  p_rx_timer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_exp |=> (rx_wb_req && pending[CAUSE_RXT]));
  p_tx_timer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_exp |=> (tx_wb_req && pending[CAUSE_TXWB]));
endmodule

// File: tb/test_irq_moderator.sv
module test_irq_moderator;
  localparam int TW = 16;
  localparam int P  = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    post_vec, post_imm, mask_wdata, cause_rdata;
  logic          mask_set_we, mask_clr_we, cause_rd, txwb_done;
  logic [TW-1:0] thr_interval, tmr_value;
  logic [3:0]    tmr_load;
  logic          rx_wb_req, tx_wb_req, irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  irq_moderator #(.TMR_W(TW), .PRESCALE(P)) i_irq_moderator (
    .clk(clk), .rst_n(rst_n), .post_vec(post_vec), .post_imm(post_imm),
    .mask_set_we(mask_set_we), .mask_clr_we(mask_clr_we),
    .mask_wdata(mask_wdata), .cause_rd(cause_rd), .cause_rdata(cause_rdata),
    .thr_interval(thr_interval), .tmr_load(tmr_load), .tmr_value(tmr_value),
    .txwb_done(txwb_done), .rx_wb_req(rx_wb_req), .tx_wb_req(tx_wb_req),
    .irq(irq)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    post_vec = '0; post_imm = '0; mask_set_we = 0; mask_clr_we = 0;
    mask_wdata = '0; cause_rd = 0; tmr_load = '0; tmr_value = '0; txwb_done = 0;
  endtask

  task automatic do_read();
    cause_rd = 1; cyc(); idle();
  endtask

  function automatic logic [7:0] m_mask(input logic [7:0] m, input logic s,
                                        input logic c, input logic [7:0] w);
    logic [7:0] r;
    r = m;
    if (s) r = r | w;
    if (c) r = r & ~w;
    return r;
  endfunction

  function automatic logic m_irq(input logic cur, input logic [7:0] pend_n,
                                 input logic [7:0] mask_n, input logic [7:0] post,
                                 input logic mwe);
    logic fire;
    fire = (|(post & mask_n)) || mwe;
    return (|(pend_n & mask_n)) && (cur || fire);
  endfunction

  initial begin
    int k;
    int seen;
    logic [7:0] mp, mm, mpn, mmn;
    logic mi;
    void'($urandom(32'd1234));
    idle();
    thr_interval = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 reset irq", irq, 0);
    chk("R1 reset pending", cause_rdata, 0);
    chk("R8 reset rx_wb_req", rx_wb_req, 0);
    chk("R9 reset tx_wb_req", tx_wb_req, 0);

    // R1/R2 masked post
    post_vec = 8'h08; cyc(); idle();
    chk("R1 masked post latched", cause_rdata, 8'h08);
    chk("R2 masked post no irq", irq, 0);
    // R6 unmask pending then mask
    mask_set_we = 1; mask_wdata = 8'h08; cyc(); idle();
    chk("R6 unmask raises irq", irq, 1);
    mask_clr_we = 1; mask_wdata = 8'h08; cyc(); idle();
    chk("R6 mask drops irq", irq, 0);
    // R6 set and clear together: clear wins
    mask_set_we = 1; mask_clr_we = 1; mask_wdata = 8'h08; cyc(); idle();
    chk("R6 clear wins", irq, 0);
    // R7 read
    cause_rd = 1; #1;
    chk("R7 read data", cause_rdata, 8'h08);
    cyc(); idle();
    chk("R7 read clears", cause_rdata, 0);

    // R2 unmasked with throttle idle
    mask_set_we = 1; mask_wdata = 8'hFF; cyc(); idle();
    post_vec = 8'h04; cyc(); idle();
    chk("R2 unmasked post irq", irq, 1);
    // R7 post in read cycle survives
    cause_rd = 1; post_vec = 8'h20; cyc(); idle();
    chk("R7 post survives read", cause_rdata, 8'h20);
    do_read();
    chk("R7 irq dropped", irq, 0);

    // R4/R5 throttle
    thr_interval = 16'd10;
    post_vec = 8'h02; cyc(); idle();          // reload edge
    chk("R5 first post irq", irq, 1);
    do_read();
    post_vec = 8'h10; cyc(); idle();
    chk("R4 held post no irq", irq, 0);
    chk("R4 held post pending", cause_rdata, 8'h10);
    k = 0;
    while (!irq && k < 60) begin cyc(); k++; end
    checks++;
    if (k < 36 || k > 39) begin
      errors++; $display("FAIL R4 release delay: actual=%0d expected=36..39", k);
    end
    // R3 immediate post during running throttle (reloaded at release)
    do_read();
    post_vec = 8'h20; post_imm = 8'h20; cyc(); idle();
    chk("R3 immediate post irq", irq, 1);
    do_read();
    post_vec = 8'h40; cyc(); idle();
    chk("R5 reload holds next post", irq, 0);
    repeat (50) cyc();
    do_read();

    // R8 receive timer, throttle long
    thr_interval = 16'd100;
    post_vec = 8'h01; post_imm = 8'h01; cyc(); idle();   // start throttle
    do_read();
    tmr_load = 4'b0001; tmr_value = 16'd3; cyc(); idle();
    k = 0;
    while (!rx_wb_req && k < 40) begin cyc(); k++; end
    checks++;
    if (k < 9 || k > 12) begin
      errors++; $display("FAIL R12 timer delay: actual=%0d expected=9..12", k);
    end
    chk("R8 rxt pending", cause_rdata[7], 1);
    chk("R8 irq immediate", irq, 1);
    chk("R8 no tx req", tx_wb_req, 0);
    cyc();
    chk("R8 req single pulse", rx_wb_req, 0);
    do_read();

    // R9 transmit absolute timer
    tmr_load = 4'b1000; tmr_value = 16'd2; cyc(); idle();
    k = 0;
    while (!tx_wb_req && k < 40) begin cyc(); k++; end
    checks++;
    if (k < 5 || k > 8) begin
      errors++; $display("FAIL R9 timer delay: actual=%0d expected=5..8", k);
    end
    chk("R9 txwb pending", cause_rdata[0], 1);
    chk("R9 irq immediate", irq, 1);
    do_read();

    // R11 load zero disables
    tmr_load = 4'b0010; tmr_value = 16'd5; cyc(); idle();
    tmr_load = 4'b0010; tmr_value = 16'd0; cyc(); idle();
    seen = 0;
    for (int i = 0; i < 40; i++) begin cyc(); if (rx_wb_req) seen++; end
    chk("R11 zero load disables", seen, 0);
    // R11 one-shot
    tmr_load = 4'b0100; tmr_value = 16'd1; cyc(); idle();
    seen = 0;
    for (int i = 0; i < 40; i++) begin cyc(); if (tx_wb_req) seen++; end
    chk("R11 one expiry", seen, 1);
    do_read();

    // R10 txwb_done is throttled (throttle reloaded by R11 expiry)
    txwb_done = 1; cyc(); idle();
    chk("R10 txwb_done posts bit0", cause_rdata, 8'h01);
    chk("R10 txwb_done throttled", irq, 0);
    thr_interval = 16'd0;
    k = 0;
    while (!irq && k < 450) begin cyc(); k++; end
    chk("R10 released after throttle", irq, 1);
    do_read();
    mask_clr_we = 1; mask_wdata = 8'hFF; cyc(); idle();
    cyc();

    // Random phase: throttle interval zero, timers idle
    mp = '0; mm = '0; mi = 0;
    for (int n = 0; n < 300; n++) begin
      logic [7:0] pv, pi, w;
      logic s, c, r;
      pv = 8'($urandom) & 8'($urandom);
      pi = 8'($urandom);
      w  = 8'($urandom);
      s  = ($urandom % 10) == 0;
      c  = ($urandom % 10) == 0;
      r  = ($urandom % 8) == 0;
      post_vec = pv; post_imm = pi; mask_wdata = w;
      mask_set_we = s; mask_clr_we = c; cause_rd = r;
      mmn = m_mask(mm, s, c, w);
      mpn = (r ? 8'h00 : mp) | pv;
      mi  = m_irq(mi, mpn, mmn, pv, s | c);
      mp = mpn; mm = mmn;
      cyc(); idle();
      chk("R2 random irq", irq, mi);
      chk("R1 random pending", cause_rdata, mp);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule